// File: doc/BRIEF.md
# Stop-State Wake-Up Controller

This block decides how a small microcontroller leaves its low-power stop state. A one-cycle request puts the block into stop. While stop is active it watches several wake sources: a watchdog time-out, level changes on enabled port pins, the external reset pin and the debug pin. Each source has a fixed outcome. A watchdog time-out or a qualified pin change starts a recovery. The external reset pin and the debug pin instead request a full system reset. A recovery waits a fixed number of cycles and then returns the block to run. A watchdog wake in interrupt mode then raises a deferred interrupt request.

The block also holds the port input register. This register follows the pins while the block runs and is frozen during stop. When a recovery ends, the register takes whatever level the pins hold at that moment. A short pulse can therefore wake the device and leave no trace in the register and no pin-change event. Two status bits record why the last recovery happened.

The controller is a three-state machine. The states are RUN, STOP and RECOVER. The transitions are: enter_stop (RUN to STOP), begin_recovery (STOP to RECOVER), finish_recovery (RECOVER to RUN) and force_reset (STOP or RECOVER to RUN, with a system reset request).

Top module: `stop_wake_ctrl`

## Requirements
- R1: A high `stop_enter` in RUN makes `in_stop` high on the next cycle. `stop_enter` has no effect in STOP or RECOVER. While `in_stop` is low, watchdog, pin, reset-pin and debug-pin inputs have no effect on any output except `port_in` and `pin_event`.
- R2: In STOP, a high `wdt_timeout` starts a recovery in either watchdog mode. On the next cycle `recovering` is high and both `stat_wdt` and `stat_stop` are 1.
- R3: In STOP, a pin whose `wake_en` bit is 1 and whose level differs from its frozen `port_in` bit for MIN_W consecutive cycles starts a recovery, whichever direction the change goes. It sets `stat_stop` to 1 and leaves `stat_wdt` at 0. A shorter difference, or a difference on a pin whose enable bit is 0, starts nothing.
- R4: In STOP or RECOVER, a low `ext_rst_n` or a low `dbg_pin_n` gives a one-cycle `sys_reset_req` on the next cycle. The block returns to RUN, clears both status bits and gives no `recovery_done`. These sources win over any wake source in the same cycle.
- R5: `recovering` stays high for exactly REC_DLY cycles. It is followed by a one-cycle `recovery_done` pulse, and `in_stop` is low during that pulse.
- R6: `wdt_irq` pulses together with `recovery_done` only when the recovery was started by the watchdog with `wdt_irq_mode`=1 and `irq_en` is 1 on the cycle the recovery ends.
- R7: `port_in` follows `gpio_in` with one cycle of latency in RUN. It holds its value through STOP and RECOVER. On the cycle the recovery ends it loads `gpio_in`.
- R8: `pin_event[i]` is high for one cycle exactly when `port_in[i]` has just changed. A wake pulse that is gone before the recovery ends therefore gives no event.
- R9: Both status bits clear on the enter_stop transition and otherwise hold until the next wake or forced reset.
- R10: After reset, the state is RUN and every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| stop_enter | input | 1 | One-cycle request to enter stop |
| wdt_timeout | input | 1 | Watchdog time-out strobe |
| wdt_irq_mode | input | 1 | 1: watchdog in interrupt mode, 0: reset mode |
| irq_en | input | 1 | Global interrupt enable |
| ext_rst_n | input | 1 | External reset pin, active low |
| dbg_pin_n | input | 1 | Debug pin, active low |
| gpio_in | input | NPINS | Port pin levels |
| wake_en | input | NPINS | Per-pin wake enable |
| in_stop | output | 1 | Stop flag, high in STOP and RECOVER |
| recovering | output | 1 | High while the recovery delay runs |
| recovery_done | output | 1 | One-cycle pulse when a recovery ends |
| sys_reset_req | output | 1 | One-cycle full system reset request |
| stat_wdt | output | 1 | Status: the watchdog caused the wake |
| stat_stop | output | 1 | Status: the wake was a stop recovery |
| wdt_irq | output | 1 | Deferred watchdog interrupt request pulse |
| port_in | output | NPINS | Port input register |
| pin_event | output | NPINS | Per-pin change pulse of the port input register |

## Verification
The bench targets pin pulses that are exactly one cycle shorter than the minimum width. A broken width filter would recover on these pulses. It also targets pulses that reach the width and then go away before the delay ends. A design that latched the waking level would show a `port_in` change and a spurious `pin_event` here.

A watchdog time-out and a reset pin in the same cycle must give a system reset. A wrong priority order gives a recovery instead. Watchdog wakes in both modes, with `irq_en` set and cleared, show whether the deferred interrupt is gated correctly or fires early.

A cycle-exact reference model runs under random stimulus. It catches a recovery delay that is off by one cycle, status bits that are not cleared on stop entry, and wake inputs that act while the block is running.

// File: rtl/swk_pkg.sv
package swk_pkg;

    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_STOP    = 2'd1,
        ST_RECOVER = 2'd2
    } swk_state_e;

endpackage

// File: rtl/swk_pin_qual.sv
// Pulse-width qualifier for one wake pin: asserts qual on the MIN_W-th
// consecutive cycle in which the armed, enabled pin differs from its reference.
module swk_pin_qual #(
    parameter int MIN_W = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic en,
    input  logic pin,
    input  logic ref_lvl,
    output logic qual
);
    localparam int FW = (MIN_W < 2) ? 1 : $clog2(MIN_W + 1);
    localparam logic [FW-1:0] LAST = FW'(MIN_W - 1);

    logic          differ;
    logic [FW-1:0] run_len;

    assign differ = arm & en & (pin ^ ref_lvl);
    assign qual   = differ && (run_len == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_len <= '0;
        end else if (!differ) begin
            run_len <= '0;
        end else if (run_len != LAST) begin
            run_len <= run_len + 1'b1;
        end
    end
endmodule

// File: rtl/swk_delay.sv
// Recovery delay counter: expire is high in the DLY-th running cycle.
module swk_delay #(
    parameter int DLY = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic expire
);
    localparam int CW = (DLY < 2) ? 1 : $clog2(DLY);
    localparam logic [CW-1:0] LAST = CW'(DLY - 1);

    logic [CW-1:0] cnt;

    assign expire = run && (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= '0;
        end else if (run && !expire) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/swk_port_reg.sv
// Port input register with a load enable and a per-bit change pulse.
module swk_port_reg #(
    parameter int NPINS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [NPINS-1:0] d,
    output logic [NPINS-1:0] q,
    output logic [NPINS-1:0] evt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q   <= '0;
            evt <= '0;
        end else if (load) begin
            q   <= d;
            evt <= d ^ q;
        end else begin
            evt <= '0;
        end
    end
endmodule

// File: rtl/stop_wake_ctrl.sv
module stop_wake_ctrl
    import swk_pkg::*;
#(
    parameter int NPINS   = 4,
    parameter int MIN_W   = 2,
    parameter int REC_DLY = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stop_enter,
    input  logic             wdt_timeout,
    input  logic             wdt_irq_mode,
    input  logic             irq_en,
    input  logic             ext_rst_n,
    input  logic             dbg_pin_n,
    input  logic [NPINS-1:0] gpio_in,
    input  logic [NPINS-1:0] wake_en,
    output logic             in_stop,
    output logic             recovering,
    output logic             recovery_done,
    output logic             sys_reset_req,
    output logic             stat_wdt,
    output logic             stat_stop,
    output logic             wdt_irq,
    output logic [NPINS-1:0] port_in,
    output logic [NPINS-1:0] pin_event
);
    swk_state_e       state, state_nx;
    logic [NPINS-1:0] pin_qual;
    logic             gpio_wake;
    logic             wake_any;
    logic             rst_src;
    logic             dly_expire;
    logic             port_load;
    logic             wdt_pend;

    assign rst_src   = !ext_rst_n || !dbg_pin_n;
    assign gpio_wake = |pin_qual;
    assign wake_any  = wdt_timeout || gpio_wake;

    // One width qualifier per pin
    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        swk_pin_qual #(.MIN_W(MIN_W)) u_qual (
            .clk     (clk),
            .rst_n   (rst_n),
            .arm     (state == ST_STOP),
            .en      (wake_en[i]),
            .pin     (gpio_in[i]),
            .ref_lvl (port_in[i]),
            .qual    (pin_qual[i])
        );
    end

    swk_delay #(.DLY(REC_DLY)) u_delay (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (state == ST_STOP),
        .run    (state == ST_RECOVER),
        .expire (dly_expire)
    );

    assign port_load = (state == ST_RUN) ||
                       ((state == ST_RECOVER) && dly_expire && !rst_src);

    swk_port_reg #(.NPINS(NPINS)) u_port (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (port_load),
        .d     (gpio_in),
        .q     (port_in),
        .evt   (pin_event)
    );

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN: begin
                if (stop_enter) state_nx = ST_STOP;              // enter_stop
            end
            ST_STOP: begin
                if (rst_src)       state_nx = ST_RUN;            // force_reset
                else if (wake_any) state_nx = ST_RECOVER;        // begin_recovery
            end
            ST_RECOVER: begin
                if (rst_src)         state_nx = ST_RUN;          // force_reset
                else if (dly_expire) state_nx = ST_RUN;          // finish_recovery
            end
            default: state_nx = ST_RUN;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nx;
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sys_reset_req <= 1'b0;
            recovery_done <= 1'b0;
            wdt_irq       <= 1'b0;
            stat_wdt      <= 1'b0;
            stat_stop     <= 1'b0;
            wdt_pend      <= 1'b0;
        end else begin
            sys_reset_req <= 1'b0;
            recovery_done <= 1'b0;
            wdt_irq       <= 1'b0;
            unique case (state)
                ST_RUN: begin
                    if (stop_enter) begin
                        stat_wdt  <= 1'b0;
                        stat_stop <= 1'b0;
                    end
                end
                ST_STOP: begin
                    if (rst_src) begin
                        sys_reset_req <= 1'b1;
                        stat_wdt      <= 1'b0;
                        stat_stop     <= 1'b0;
                        wdt_pend      <= 1'b0;
                    end else if (wake_any) begin
                        stat_stop <= 1'b1;
                        stat_wdt  <= wdt_timeout;
                        wdt_pend  <= wdt_timeout && wdt_irq_mode;
                    end
                end
                ST_RECOVER: begin
                    if (rst_src) begin
                        sys_reset_req <= 1'b1;
                        stat_wdt      <= 1'b0;
                        stat_stop     <= 1'b0;
                        wdt_pend      <= 1'b0;
                    end else if (dly_expire) begin
                        recovery_done <= 1'b1;
                        wdt_irq       <= wdt_pend && irq_en;
                        wdt_pend      <= 1'b0;
                    end
                end
                default: begin
                    wdt_pend <= 1'b0;
                end
            endcase
        end
    end

    assign in_stop    = (state != ST_RUN);
    assign recovering = (state == ST_RECOVER);

endmodule

// File: rtl/swk_checker.sv
module swk_checker #(
    parameter int NPINS   = 4,
    parameter int REC_DLY = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             stop_enter,
    input logic             wdt_timeout,
    input logic             ext_rst_n,
    input logic             dbg_pin_n,
    input logic             in_stop,
    input logic             recovering,
    input logic             recovery_done,
    input logic             sys_reset_req,
    input logic             stat_wdt,
    input logic             stat_stop,
    input logic             wdt_irq,
    input logic [NPINS-1:0] port_in,
    input logic [NPINS-1:0] pin_event
);
    localparam int LW = $clog2(REC_DLY + 1) + 1;
    logic [LW-1:0] rec_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          rec_len <= '0;
        else if (recovering) rec_len <= rec_len + 1'b1;
        else                 rec_len <= '0;
    end

    assert_stop_entry_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_stop && stop_enter) |=> in_stop);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_stop |=> (!recovering && !sys_reset_req));

    assert_wdt_wake_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_stop && !recovering && wdt_timeout && ext_rst_n && dbg_pin_n)
        |=> (recovering && stat_wdt && stat_stop));

    assert_reset_prio_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_stop && (!ext_rst_n || !dbg_pin_n))
        |=> (sys_reset_req && !in_stop && !recovery_done && !stat_stop));

    assert_done_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        recovery_done |-> (!in_stop && rec_len == LW'(REC_DLY)));

    assert_irq_with_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_irq |-> recovery_done);

    assert_port_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_stop && $past(in_stop)) |-> $stable(port_in));

    assert_event_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (pin_event == (port_in ^ $past(port_in))));

    assert_stat_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_stop && stop_enter) |=> (!stat_wdt && !stat_stop));

    assert_stat_zero_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_stop) |-> !stat_wdt);
endmodule

bind stop_wake_ctrl swk_checker #(.NPINS(NPINS), .REC_DLY(REC_DLY)) u_swk_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .stop_enter    (stop_enter),
    .wdt_timeout   (wdt_timeout),
    .ext_rst_n     (ext_rst_n),
    .dbg_pin_n     (dbg_pin_n),
    .in_stop       (in_stop),
    .recovering    (recovering),
    .recovery_done (recovery_done),
    .sys_reset_req (sys_reset_req),
    .stat_wdt      (stat_wdt),
    .stat_stop     (stat_stop),
    .wdt_irq       (wdt_irq),
    .port_in       (port_in),
    .pin_event     (pin_event)
);

// File: tb/stop_wake_ctrl_test.sv
module stop_wake_ctrl_test;
    localparam int CLK_P   = 10;
    localparam int NPINS   = 4;
    localparam int MIN_W   = 2;
    localparam int REC_DLY = 16;

    logic clk = 1'b0;
    logic rst_n;
    logic stop_enter, wdt_timeout, wdt_irq_mode, irq_en, ext_rst_n, dbg_pin_n;
    logic [NPINS-1:0] gpio_in, wake_en;
    logic in_stop, recovering, recovery_done, sys_reset_req;
    logic stat_wdt, stat_stop, wdt_irq;
    logic [NPINS-1:0] port_in, pin_event;

    int n_chk = 0;
    int n_fail = 0;
    bit cmp_on = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    stop_wake_ctrl #(.NPINS(NPINS), .MIN_W(MIN_W), .REC_DLY(REC_DLY)) uut (
        .clk(clk), .rst_n(rst_n), .stop_enter(stop_enter),
        .wdt_timeout(wdt_timeout), .wdt_irq_mode(wdt_irq_mode), .irq_en(irq_en),
        .ext_rst_n(ext_rst_n), .dbg_pin_n(dbg_pin_n), .gpio_in(gpio_in),
        .wake_en(wake_en), .in_stop(in_stop), .recovering(recovering),
        .recovery_done(recovery_done), .sys_reset_req(sys_reset_req),
        .stat_wdt(stat_wdt), .stat_stop(stat_stop), .wdt_irq(wdt_irq),
        .port_in(port_in), .pin_event(pin_event)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model: 0=run, 1=stop, 2=recover
    int               m_st, m_cnt;
    int               m_run [NPINS];
    logic [NPINS-1:0] m_port, m_evt, p_nxt;
    logic m_done, m_sysrst, m_swdt, m_sstop, m_pend, m_irq;

    function automatic bit reset_source(input logic er_n, input logic db_n);
        return (!er_n) || (!db_n);
    endfunction

    always @(posedge clk) begin
        bit rs, gw;
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_port = '0; m_evt = '0;
            m_done = 0; m_sysrst = 0; m_swdt = 0; m_sstop = 0; m_pend = 0; m_irq = 0;
            for (int i = 0; i < NPINS; i++) m_run[i] = 0;
        end else begin
            rs = reset_source(ext_rst_n, dbg_pin_n);
            gw = 0;
            for (int i = 0; i < NPINS; i++) begin
                if (m_st == 1 && wake_en[i] && gpio_in[i] != m_port[i]) begin
                    m_run[i] = m_run[i] + 1;
                    if (m_run[i] >= MIN_W) gw = 1;
                end else begin
                    m_run[i] = 0;
                end
            end
            p_nxt = m_port; m_done = 0; m_sysrst = 0; m_irq = 0;
            case (m_st)
                0: begin
                    p_nxt = gpio_in;
                    if (stop_enter) begin m_st = 1; m_swdt = 0; m_sstop = 0; end
                end
                1: begin
                    if (rs) begin
                        m_st = 0; m_sysrst = 1; m_swdt = 0; m_sstop = 0; m_pend = 0;
                    end else if (wdt_timeout || gw) begin
                        m_st = 2; m_cnt = 0; m_sstop = 1; m_swdt = wdt_timeout;
                        m_pend = wdt_timeout && wdt_irq_mode;
                    end
                end
                default: begin
                    if (rs) begin
                        m_st = 0; m_sysrst = 1; m_swdt = 0; m_sstop = 0; m_pend = 0;
                    end else if (m_cnt == REC_DLY - 1) begin
                        m_st = 0; m_done = 1; m_irq = m_pend && irq_en; m_pend = 0;
                        p_nxt = gpio_in;
                    end else begin
                        m_cnt = m_cnt + 1;
                    end
                end
            endcase
            m_evt  = p_nxt ^ m_port;
            m_port = p_nxt;
        end
    end

    always @(negedge clk) begin
        if (cmp_on) begin
            chk("R1 in_stop", 32'(in_stop), 32'(m_st != 0));
            chk("R5 recovering", 32'(recovering), 32'(m_st == 2));
            chk("R5 recovery_done", 32'(recovery_done), 32'(m_done));
            chk("R4 sys_reset_req", 32'(sys_reset_req), 32'(m_sysrst));
            chk("R2 stat_wdt", 32'(stat_wdt), 32'(m_swdt));
            chk("R3 R9 stat_stop", 32'(stat_stop), 32'(m_sstop));
            chk("R6 wdt_irq", 32'(wdt_irq), 32'(m_irq));
            chk("R7 port_in", 32'(port_in), 32'(m_port));
            chk("R8 pin_event", 32'(pin_event), 32'(m_evt));
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic go_stop();
        stop_enter = 1'b1;
        tick();
        stop_enter = 1'b0;
    endtask

    initial begin
        int seed;
        rst_n = 1'b0; stop_enter = 0; wdt_timeout = 0; wdt_irq_mode = 0; irq_en = 0;
        ext_rst_n = 1; dbg_pin_n = 1; gpio_in = '0; wake_en = 4'b0001;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: reset state
        chk("R10 in_stop", 32'(in_stop), 0);
        chk("R10 outputs", 32'({recovering, recovery_done, sys_reset_req, stat_wdt, stat_stop, wdt_irq}), 0);
        chk("R10 port_in", 32'(port_in), 0);
        @(posedge clk); #1;
        rst_n = 1'b1; cmp_on = 1'b1;
        repeat (3) tick();

        // R3: one-cycle pulse on an enabled pin is too short
        go_stop();
        tick();
        gpio_in[0] = 1'b1; tick();
        gpio_in[0] = 1'b0; tick();
        repeat (2) tick();
        @(negedge clk);
        chk("R3 short pulse no recovery", 32'(recovering), 0);
        chk("R3 still stopped", 32'(in_stop), 1);

        // R3: disabled pin held long does nothing
        tick();
        gpio_in[2] = 1'b1; repeat (5) tick();
        @(negedge clk);
        chk("R3 disabled pin ignored", 32'(recovering), 0);
        tick();
        gpio_in[2] = 1'b0; tick();

        // R3/R8: two-cycle pulse wakes but is gone before the end
        gpio_in[0] = 1'b1; repeat (2) tick();
        gpio_in[0] = 1'b0;
        @(negedge clk);
        chk("R3 qualified pulse recovers", 32'(recovering), 1);
        chk("R3 gpio cause only", 32'({stat_wdt, stat_stop}), 32'b01);
        repeat (REC_DLY + 2) tick();
        @(negedge clk);
        chk("R5 back in run", 32'(in_stop), 0);
        chk("R8 short pulse unrecorded", 32'(port_in[0]), 0);

        // R6: watchdog interrupt mode with interrupts enabled
        tick();
        go_stop();
        wdt_timeout = 1; wdt_irq_mode = 1; irq_en = 1; tick();
        wdt_timeout = 0;
        for (int k = 0; k < REC_DLY + 4; k++) begin
            @(negedge clk);
            if (recovery_done) break;
        end
        chk("R5 recovery_done seen", 32'(recovery_done), 1);
        chk("R6 deferred wdt irq", 32'(wdt_irq), 1);
        chk("R2 wdt cause bits", 32'({stat_wdt, stat_stop}), 32'b11);

        // R4: reset pin and watchdog together
        tick();
        go_stop();
        wdt_timeout = 1; ext_rst_n = 0; tick();
        wdt_timeout = 0; ext_rst_n = 1;
        @(negedge clk);
        chk("R4 reset wins", 32'(sys_reset_req), 1);
        chk("R4 no recovery", 32'(recovering), 0);
        chk("R4 left stop", 32'(in_stop), 0);

        // R1: wake inputs in run are ignored
        tick();
        wdt_timeout = 1; dbg_pin_n = 0; tick();
        wdt_timeout = 0; dbg_pin_n = 1;
        @(negedge clk);
        chk("R1 ignored in run", 32'({in_stop, sys_reset_req, recovering}), 0);

        // Random phase
        seed = 32'h5EED1234;
        void'($urandom(seed));
        for (int c = 0; c < 6000; c++) begin
            tick();
            stop_enter   = ($urandom % 10) == 0;
            wdt_timeout  = ($urandom % 45) == 0;
            wdt_irq_mode = $urandom % 2;
            irq_en       = ($urandom % 3) != 0;
            ext_rst_n    = ($urandom % 150) != 0;
            dbg_pin_n    = ($urandom % 150) != 0;
            if (($urandom % 50) == 0) wake_en = NPINS'($urandom);
            for (int i = 0; i < NPINS; i++)
                if (($urandom % 6) == 0) gpio_in[i] = ~gpio_in[i];
        end
        tick();
        cmp_on = 1'b0;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule